// File: doc/BRIEF.md
# Serial Four-Channel Converter Write Port

This block takes 16-bit write frames over a three-wire serial link (serial clock, active-low frame select, serial data) and loads them into four 12-bit channel registers that drive the converter cores. A frame opens when the frame select goes low. Bits are taken on each falling edge of the serial clock, most significant bit first. The upper four bits form a channel-enable mask and the lower twelve bits form the value. The value is written only when the sixteenth falling edge arrives. If the frame select rises before that edge, the frame is dropped and the partial word is discarded.

All three serial inputs are resynchronised into the block clock domain through a parameterised flop chain. Falling serial clock edges are found by comparing consecutive synchronised samples. A four-state controller sequences each frame. The states are IDLE, SHIFT, COMMIT and HOLD. The transitions are:
- Open: IDLE to SHIFT, when the select goes low.
- Abort: SHIFT to IDLE, when the select goes high early.
- Complete: SHIFT to COMMIT, on the sixteenth falling edge.
- Settle: COMMIT to HOLD.
- Release: COMMIT or HOLD to IDLE, when the select goes high.

Top module: `qdac_serial_port`

## Requirements
- R1: While `rst_n` is low, and after it is released, every channel register reads zero and `dac_upd` is zero. This holds until a complete frame is received.
- R2: Frame bits arrive most significant first. Bits 15..12 are the channel mask, and bit 12+i enables channel i. Bits 11..0 are the value, and channel i appears at `dac_data[12*i +: 12]`.
- R3: Bits are sampled only on falling edges of `sclk` while `sync_n` is low. Serial clock activity while `sync_n` is high changes no register and raises no strobe.
- R4: A frame writes its value on the sixteenth falling edge after `sync_n` goes low, and never on an earlier edge.
- R5: A rise of `sync_n` before the sixteenth falling edge discards the frame. No channel changes and no strobe is raised. The next frame decodes exactly as if the aborted one had never been sent.
- R6: A mask with several bits set writes the same value to each of those channels. A mask of zero writes no channel.
- R7: After the sixteenth edge, further falling edges are ignored until `sync_n` goes high and then low again. Each frame commits at most once.
- R8: For each written channel, `dac_upd[i]` is high for exactly one block-clock cycle, in the cycle in which the new value first appears on `dac_data`.
- R9: Channels not enabled by a committed frame keep their previous value.
- R10: Asserting `rst_n` in the middle of a frame clears all channels and abandons the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset (power-on clear) |
| sclk | input | 1 | Serial clock, idles high; data is taken on its falling edges |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data, most significant bit first |
| dac_data | output | 48 | Four 12-bit channel registers, channel i at bits 12*i+11..12*i |
| dac_upd | output | 4 | One-cycle per-channel load strobe |

## Verification
The assertions assume that the serial inputs change slowly compared with the block clock. Each `sclk` level, and each `sync_n` change, must last longer than the synchroniser depth plus one cycle, so that no falling edge is missed or counted twice. They also assume that `sync_n` does not fall in the same block cycle as an `sclk` falling edge. The stimulus holds each serial clock phase for four block cycles. It moves `sync_n` and `sdin` only while `sclk` is high, and well away from any falling edge. Reset is released on a block-clock falling edge, so no check sees a partial reset.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_HOLD   = 2'd3
    } frame_st_t;

endpackage

// File: rtl/qdac_sdi_sync.sv
module qdac_sdi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sync_n,
    input  logic sdin,
    output logic sclk_fall,
    output logic sync_hi,
    output logic sdin_s
);
    logic [STAGES-1:0] sclk_ch;
    logic [STAGES-1:0] sync_ch;
    logic [STAGES-1:0] data_ch;
    logic              sclk_prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_ch <= 1'b1;
                    sync_ch <= 1'b1;
                    data_ch <= 1'b0;
                end else begin
                    sclk_ch <= sclk;
                    sync_ch <= sync_n;
                    data_ch <= sdin;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_ch <= '1;
                    sync_ch <= '1;
                    data_ch <= '0;
                end else begin
                    sclk_ch <= {sclk_ch[STAGES-2:0], sclk};
                    sync_ch <= {sync_ch[STAGES-2:0], sync_n};
                    data_ch <= {data_ch[STAGES-2:0], sdin};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b1;
        else        sclk_prev <= sclk_ch[STAGES-1];
    end

    assign sclk_fall = sclk_prev & ~sclk_ch[STAGES-1];
    assign sync_hi   = sync_ch[STAGES-1];
    assign sdin_s    = data_ch[STAGES-1];
endmodule

// File: rtl/qdac_frame_fsm.sv
module qdac_frame_fsm
    import qdac_pkg::*;
#(
    parameter int MASK_W = 4,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall,
    input  logic              sync_hi,
    input  logic              sdin_s,
    output frame_st_t         state,
    output logic              wr_en,
    output logic [MASK_W-1:0] wr_mask,
    output logic [DATA_W-1:0] wr_data
);
    localparam int FRAME_W = MASK_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    frame_st_t          nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic               take_bit;
    logic               last_edge;

    assign take_bit  = (state == ST_IDLE || state == ST_SHIFT) && !sync_hi && sclk_fall;
    assign last_edge = take_bit && (bit_cnt == LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!sync_hi) nxt = ST_SHIFT;
            ST_SHIFT:  if (sync_hi) nxt = ST_IDLE;
                       else if (last_edge) nxt = ST_COMMIT;
            ST_COMMIT: nxt = sync_hi ? ST_IDLE : ST_HOLD;
            ST_HOLD:   if (sync_hi) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sync_hi && (state == ST_IDLE || state == ST_SHIFT)) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (take_bit) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[FRAME_W-2:0], sdin_s};
        end
    end

    always_comb begin
        wr_en   = (state == ST_COMMIT);
        wr_mask = shreg[FRAME_W-1 -: MASK_W];
        wr_data = shreg[DATA_W-1:0];
    end
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank #(
    parameter int N_CH   = 4,
    parameter int DATA_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [N_CH-1:0]          wr_mask,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [N_CH*DATA_W-1:0]   dac_data,
    output logic [N_CH-1:0]          dac_upd
);
    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dac_data[i*DATA_W +: DATA_W] <= '0;
                    dac_upd[i]                   <= 1'b0;
                end else if (wr_en && wr_mask[i]) begin
                    dac_data[i*DATA_W +: DATA_W] <= wr_data;
                    dac_upd[i]                   <= 1'b1;
                end else begin
                    dac_upd[i]                   <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/qdac_serial_port.sv
module qdac_serial_port
    import qdac_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   sync_n,
    input  logic                   sdin,
    output logic [N_CH*DATA_W-1:0] dac_data,
    output logic [N_CH-1:0]        dac_upd
);
    logic             sclk_fall;
    logic             sync_hi;
    logic             sdin_s;
    frame_st_t        frame_state;
    logic             wr_en;
    logic [N_CH-1:0]  wr_mask;
    logic [DATA_W-1:0] wr_data;

    qdac_sdi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .sync_n    (sync_n),
        .sdin      (sdin),
        .sclk_fall (sclk_fall),
        .sync_hi   (sync_hi),
        .sdin_s    (sdin_s)
    );

    qdac_frame_fsm #(.MASK_W(N_CH), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_fall (sclk_fall),
        .sync_hi   (sync_hi),
        .sdin_s    (sdin_s),
        .state     (frame_state),
        .wr_en     (wr_en),
        .wr_mask   (wr_mask),
        .wr_data   (wr_data)
    );

    qdac_chan_bank #(.N_CH(N_CH), .DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_mask  (wr_mask),
        .wr_data  (wr_data),
        .dac_data (dac_data),
        .dac_upd  (dac_upd)
    );
endmodule

// File: rtl/qdac_serial_port_chk.sv
module qdac_serial_port_chk
    import qdac_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int DATA_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sync_hi,
    input frame_st_t              frame_state,
    input logic                   wr_en,
    input logic [N_CH-1:0]        wr_mask,
    input logic [N_CH*DATA_W-1:0] dac_data,
    input logic [N_CH-1:0]        dac_upd
);
    // R8 / R6: strobes follow exactly the mask of the committing frame
    assert_upd_follows_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (dac_upd == $past(wr_mask)));

    // R4: a strobe only ever appears right after a commit
    assert_upd_needs_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_upd != '0) |-> $past(wr_en));

    // R7: one commit per frame
    assert_single_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5: a high select never leaves the controller shifting
    assert_abort_leaves_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hi |=> (frame_state == ST_IDLE || frame_state == ST_HOLD));

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_hold
            // R9: a channel without a strobe keeps its value
            assert_hold_unwritten_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !dac_upd[i] |-> (dac_data[i*DATA_W +: DATA_W] == $past(dac_data[i*DATA_W +: DATA_W])));
        end
    endgenerate
endmodule

bind qdac_serial_port qdac_serial_port_chk #(.N_CH(N_CH), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_hi     (sync_hi),
    .frame_state (frame_state),
    .wr_en       (wr_en),
    .wr_mask     (wr_mask),
    .dac_data    (dac_data),
    .dac_upd     (dac_upd)
);

// File: tb/qdac_serial_port_test.sv
module qdac_serial_port_test;
    localparam int N_CH = 4;
    localparam int DW   = 12;
    localparam int NV   = 9;
    // each entry: {falling edges sent [7:0], frame word [15:0]}
    localparam logic [23:0] VEC [NV] = '{
        {8'd16, 16'h1ABC}, {8'd16, 16'h8123}, {8'd16, 16'h6F0F},
        {8'd16, 16'h0555}, {8'd10, 16'h4777}, {8'd15, 16'h2999},
        {8'd20, 16'h2444}, {8'd16, 16'hF000}, {8'd16, 16'h8FFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic sync_n = 1'b1;
    logic sdin = 1'b0;
    logic [N_CH*DW-1:0] dac_data;
    logic [N_CH-1:0]    dac_upd;

    int n_chk = 0;
    int n_bad = 0;
    int upd_cnt [N_CH];
    int wide_cnt = 0;
    logic [N_CH-1:0] upd_prev = '0;
    logic [DW-1:0] mdl [N_CH];
    int exp_cnt [N_CH];

    always #2 clk = ~clk;

    qdac_serial_port uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n),
        .sdin(sdin), .dac_data(dac_data), .dac_upd(dac_upd)
    );

    initial for (int i = 0; i < N_CH; i++) upd_cnt[i] = 0;

    always @(negedge clk) begin
        for (int i = 0; i < N_CH; i++) begin
            if (dac_upd[i]) upd_cnt[i] = upd_cnt[i] + 1;
            if (dac_upd[i] && upd_prev[i]) wide_cnt = wide_cnt + 1;
        end
        upd_prev = dac_upd;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N_CH*DW-1:0] mdl_flat();
        logic [N_CH*DW-1:0] f;
        for (int i = 0; i < N_CH; i++) f[i*DW +: DW] = mdl[i];
        return f;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w, input int edges);
        sync_n = 1'b0;
        wait_clk(4);
        for (int k = 0; k < edges; k++) begin
            sclk = 1'b1;
            sdin = (k < 16) ? w[15-k] : 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
        end
        sclk = 1'b1;
        wait_clk(4);
        sync_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic model(input logic [15:0] w, input int edges);
        if (edges >= 16)
            for (int i = 0; i < N_CH; i++)
                if (w[12+i]) begin
                    mdl[i] = w[11:0];
                    exp_cnt[i]++;
                end
    endtask

    task automatic check_cnts(input string req);
        for (int i = 0; i < N_CH; i++)
            check(upd_cnt[i] == exp_cnt[i], req, 64'(upd_cnt[i]), 64'(exp_cnt[i]));
    endtask

    initial begin
        for (int i = 0; i < N_CH; i++) begin
            mdl[i] = '0;
            exp_cnt[i] = 0;
        end
        wait_clk(3);
        // R1: held in reset
        check(dac_data == '0 && dac_upd == '0, "R1", 64'(dac_data), 64'd0);
        rst_n = 1'b1;
        wait_clk(5);
        check(dac_data == '0 && dac_upd == '0, "R1", 64'(dac_data), 64'd0);

        for (int v = 0; v < NV; v++) begin
            logic [15:0] w;
            int e;
            string req;
            w = VEC[v][15:0];
            e = int'(VEC[v][23:16]);
            send(w, e);
            model(w, e);
            req = (e < 16) ? "R5" : (e > 16) ? "R7" : (w[15:12] == 4'd0) ? "R6" :
                  ($countones(w[15:12]) > 1) ? "R6" : "R2/R4/R9";
            check(dac_data == mdl_flat(), req, 64'(dac_data), 64'(mdl_flat()));
            check_cnts("R8");
        end

        // R3: serial clock toggling with select high
        sdin = 1'b1;
        for (int k = 0; k < 16; k++) begin
            sclk = 1'b0; wait_clk(4);
            sclk = 1'b1; wait_clk(4);
        end
        wait_clk(8);
        check(dac_data == mdl_flat(), "R3", 64'(dac_data), 64'(mdl_flat()));
        check_cnts("R3");

        // R5: aborted at 15 edges then a clean frame decodes correctly
        send(16'h1FFF, 15);
        send(16'h1246, 16);
        model(16'h1246, 16);
        check(dac_data == mdl_flat(), "R5", 64'(dac_data), 64'(mdl_flat()));

        // R8: no strobe ever lasted more than one cycle
        check(wide_cnt == 0, "R8", 64'(wide_cnt), 64'd0);

        // R10: reset in the middle of a frame
        sync_n = 1'b0;
        wait_clk(4);
        for (int k = 0; k < 8; k++) begin
            sclk = 1'b1; sdin = 1'b1; wait_clk(4);
            sclk = 1'b0; wait_clk(4);
        end
        rst_n = 1'b0;
        sclk = 1'b1;
        sync_n = 1'b1;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(8);
        for (int i = 0; i < N_CH; i++) mdl[i] = '0;
        check(dac_data == '0, "R10", 64'(dac_data), 64'd0);
        send(16'h4321, 16);
        model(16'h4321, 16);
        check(dac_data == mdl_flat(), "R10", 64'(dac_data), 64'(mdl_flat()));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule